// File: doc/BRIEF.md
# Multi-channel tamper input detector

The block watches up to eight external tamper pins. Each channel is configured through one 32-bit control word. A 2-bit action field selects what the channel does: nothing, a wake request, or a timestamp capture. The action field can also select an active-shield check. In the wake and capture actions the channel looks for one chosen edge on its pin. An optional debounce filter is clocked by a slow tick and sits in front of the edge detector.

In the shield action the channel drives a shared reference waveform out on its output pin. It expects the same waveform to come back on its input pin. Any difference that persists is treated as a tamper, and in this action the edge and debounce settings play no part.

Every tamper event sets a sticky per-channel flag, which software clears by writing ones. Capture and shield events also freeze a free-running counter value together with the number of the channel that caused it. The control word is only writable while the block's enable is low.

Top module: `tamper_detect`

## Requirements
- R1: After reset the control word, all flags, `ts_valid`, `wake` and all `tamp_out` bits are 0.
- R2: A control write with `ctrl_we` high takes effect only while `enable` is 0. While `enable` is 1 the write is ignored and `ctrl_rdata` keeps its value.
- R3: Control bits [2n+1:2n] hold channel n's action: 0 off, 1 wake, 2 capture, 3 shield. A channel with action 0 never sets its flag.
- R4: Control bit 16+n picks channel n's edge: 0 means falling, 1 means rising. The opposite edge sets no flag in the wake and capture actions.
- R5: A qualifying edge on a wake channel sets its flag. `wake` is high while any wake-action channel's flag is set, and the event does not touch the timestamp.
- R6: A qualifying event on a capture or shield channel sets its flag. When no timestamp is held it also loads `ts_value` from `ts_count`, loads `ts_chan` with the channel number and sets `ts_valid`. When several channels fire together, the lowest-numbered channel is recorded.
- R7: A held timestamp ignores later captures. It is released only when the recorded channel's flag is cleared, and the next capture then loads afresh.
- R8: Flags are sticky. Writing 1 to bit n of `flag_clr` with `flag_clr_we` high clears flag n. A new event on the same channel in the same cycle leaves the flag set.
- R9: With control bit 24+n set, a pin level must differ from the filtered level for 3 consecutive `slow_tick` pulses before the edge counts, so shorter pulses set no flag. With the bit clear, a pulse of a few clock cycles is detected.
- R10: In the shield action and with `enable` high, `tamp_out[n]` follows the registered `shield_ref`. In all other cases `tamp_out[n]` is 0. A returned input that differs from what was driven sets the flag and captures the timestamp.
- R11: In the shield action, the edge and debounce bits have no effect. A returned input lagging by one extra clock cycle is tolerated, because the compare skips the first cycle after each reference transition.
- R12: While `enable` is 0 no flag is set. Enabling with a pin already at its active level produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; also locks the control word |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Current control word |
| slow_tick | input | 1 | Debounce sampling tick, one clock wide |
| shield_ref | input | 1 | Reference waveform for shield channels |
| tamp_in | input | NUM_CH | Tamper input pins |
| tamp_out | output | NUM_CH | Shield drive pins |
| ts_count | input | TS_W | Free-running timestamp counter |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr | input | NUM_CH | Write-one-to-clear mask for flags |
| flags | output | NUM_CH | Sticky tamper flags |
| ts_valid | output | 1 | A timestamp is held |
| ts_value | output | TS_W | Captured counter value |
| ts_chan | output | CH_W | Channel that caused the capture |
| wake | output | 1 | Wake request |

## Verification
Some properties are checked on every cycle. The control lock must hold. Flags may fall only through a clear. No flag may rise while the block is disabled. A held timestamp must stay frozen and must always point at a set flag. Shield drive must stay off on non-shield channels, and `wake` must never be high without a flag.

Other behaviour can only be shown by the directed scenarios. These cover edge polarity, the debounce window against short and long pulses, and the lowest-channel and release rules of the timestamp. They also cover the exact cycle in which a clear collides with a new event, and the shield compare's tolerance of one cycle of skew against its detection of a broken loop.

// File: rtl/tamper_pkg.sv
package tamper_pkg;

   localparam int CTRL_W  = 32;
   localparam int POL_LSB = 16;
   localparam int DEB_LSB = 24;
   localparam int MAX_CH  = 8;

   typedef enum logic [1:0] {
      ACT_OFF     = 2'd0,
      ACT_WAKE    = 2'd1,
      ACT_CAPTURE = 2'd2,
      ACT_SHIELD  = 2'd3
   } act_e;

   function automatic act_e ctrl_act(input logic [CTRL_W-1:0] w, input int ch);
      return act_e'(w[2*ch +: 2]);
   endfunction

   function automatic logic ctrl_pol(input logic [CTRL_W-1:0] w, input int ch);
      return w[POL_LSB + ch];
   endfunction

   function automatic logic ctrl_deb(input logic [CTRL_W-1:0] w, input int ch);
      return w[DEB_LSB + ch];
   endfunction

endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/tamper_chan.sv
module tamper_chan
   import tamper_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_TICKS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  act_e mode,
   input  logic pol,
   input  logic deb_en,
   input  logic slow_tick,
   input  logic ref_bit,
   input  logic pin_in,
   output logic pin_out,
   output logic hit
);
   logic pin_s;
   logic lvl;
   logic prev;
   logic edge_hit;
   logic shield;
   logic settled;
   logic mismatch;
   logic [SYNC_STAGES:0] dly;

   tamper_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   generate
      if (DEB_TICKS > 0) begin : g_deb
         localparam int CW = $clog2(DEB_TICKS + 1);
         logic          filt;
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt <= 1'b0;
               cnt  <= '0;
            end else if (!deb_en || pin_s == filt) begin
               filt <= pin_s;
               cnt  <= '0;
            end else if (slow_tick) begin
               if (cnt == CW'(DEB_TICKS - 1)) begin
                  filt <= pin_s;
                  cnt  <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end

         assign lvl = deb_en ? filt : pin_s;
      end else begin : g_nodeb
         assign lvl = pin_s;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b0;
         dly  <= '0;
      end else begin
         prev <= lvl;
         dly  <= {dly[SYNC_STAGES-1:0], pin_out};
      end
   end

   assign edge_hit = (lvl != prev) && (lvl == pol);
   assign shield   = enable && (mode == ACT_SHIELD);
   assign pin_out  = shield & ref_bit;
   assign settled  = dly[SYNC_STAGES-1] == dly[SYNC_STAGES];
   assign mismatch = pin_s != dly[SYNC_STAGES-1];

   always_comb begin
      hit = 1'b0;
      if (enable) begin
         unique case (mode)
            ACT_WAKE, ACT_CAPTURE: hit = edge_hit;
            ACT_SHIELD:            hit = settled && mismatch;
            default:               hit = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/tamper_detect.sv
module tamper_detect
   import tamper_pkg::*;
#(
   parameter  int NUM_CH      = 8,
   parameter  int TS_W        = 32,
   parameter  int SYNC_STAGES = 2,
   parameter  int DEB_TICKS   = 3,
   localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_rdata,
   input  logic              slow_tick,
   input  logic              shield_ref,
   input  logic [NUM_CH-1:0] tamp_in,
   output logic [NUM_CH-1:0] tamp_out,
   input  logic [TS_W-1:0]   ts_count,
   input  logic              flag_clr_we,
   input  logic [NUM_CH-1:0] flag_clr,
   output logic [NUM_CH-1:0] flags,
   output logic              ts_valid,
   output logic [TS_W-1:0]   ts_value,
   output logic [CH_W-1:0]   ts_chan,
   output logic              wake
);
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("tamper_detect: NUM_CH must lie in 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tamper_detect: SYNC_STAGES must be at least 2");
   end
   if (TS_W < 1) begin : g_bad_ts
      $error("tamper_detect: TS_W must be positive");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic              ref_q;
   logic [NUM_CH-1:0] hit;
   logic [NUM_CH-1:0] cap_mask;
   logic [NUM_CH-1:0] wake_mask;
   logic [NUM_CH-1:0] clr_eff;
   logic [NUM_CH-1:0] cap_hit;
   logic [CH_W-1:0]   cap_idx;
   logic              ts_keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ref_q  <= 1'b0;
      end else begin
         ref_q <= shield_ref;
         if (ctrl_we && !enable) ctrl_q <= ctrl_wdata;
      end
   end

   assign ctrl_rdata = ctrl_q;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      act_e mode_i;
      assign mode_i       = ctrl_act(ctrl_q, i);
      assign cap_mask[i]  = (mode_i == ACT_CAPTURE) || (mode_i == ACT_SHIELD);
      assign wake_mask[i] = (mode_i == ACT_WAKE);

      tamper_chan #(
         .SYNC_STAGES (SYNC_STAGES),
         .DEB_TICKS   (DEB_TICKS)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .enable    (enable),
         .mode      (mode_i),
         .pol       (ctrl_pol(ctrl_q, i)),
         .deb_en    (ctrl_deb(ctrl_q, i)),
         .slow_tick (slow_tick),
         .ref_bit   (ref_q),
         .pin_in    (tamp_in[i]),
         .pin_out   (tamp_out[i]),
         .hit       (hit[i])
      );
   end

   assign clr_eff = flag_clr_we ? flag_clr : '0;
   assign cap_hit = hit & cap_mask;
   assign ts_keep = ts_valid && !(clr_eff[ts_chan] && !hit[ts_chan]);

   always_comb begin
      cap_idx = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (cap_hit[i]) cap_idx = CH_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags    <= '0;
         ts_valid <= 1'b0;
         ts_value <= '0;
         ts_chan  <= '0;
      end else begin
         flags <= (flags & ~clr_eff) | hit;
         if (!ts_keep && (|cap_hit)) begin
            ts_valid <= 1'b1;
            ts_value <= ts_count;
            ts_chan  <= cap_idx;
         end else begin
            ts_valid <= ts_keep;
         end
      end
   end

   assign wake = |(flags & wake_mask);
endmodule

// File: rtl/tamper_detect_chk.sv
module tamper_detect_chk #(
   parameter int NUM_CH = 8,
   parameter int TS_W   = 32,
   parameter int CH_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              ctrl_we,
   input logic [31:0]       ctrl_rdata,
   input logic              flag_clr_we,
   input logic [NUM_CH-1:0] flag_clr,
   input logic [NUM_CH-1:0] flags,
   input logic [NUM_CH-1:0] tamp_out,
   input logic              ts_valid,
   input logic [TS_W-1:0]   ts_value,
   input logic [CH_W-1:0]   ts_chan,
   input logic              wake
);
   logic [NUM_CH-1:0] shield_mask;
   logic [NUM_CH-1:0] clr_mask;

   always_comb begin
      for (int i = 0; i < NUM_CH; i++) begin
         shield_mask[i] = enable && (ctrl_rdata[2*i +: 2] == 2'b11);
      end
   end

   assign clr_mask = flag_clr_we ? flag_clr : '0;

   // R2
   ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable || !ctrl_we) |=> $stable(ctrl_rdata));

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((($past(flags) & ~$past(clr_mask)) & ~flags) == '0));

   // R12
   no_flag_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> ((flags & ~$past(flags)) == '0));

   // R7
   ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ts_valid && !clr_mask[ts_chan]) |=> (ts_valid && $stable(ts_value) && $stable(ts_chan)));

   // R6
   ts_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_valid |-> flags[ts_chan]);

   // R10
   shield_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tamp_out & ~shield_mask) == '0);

   // R5
   wake_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (flags != '0));
endmodule

bind tamper_detect tamper_detect_chk #(
   .NUM_CH (NUM_CH),
   .TS_W   (TS_W),
   .CH_W   (CH_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable      (enable),
   .ctrl_we     (ctrl_we),
   .ctrl_rdata  (ctrl_rdata),
   .flag_clr_we (flag_clr_we),
   .flag_clr    (flag_clr),
   .flags       (flags),
   .tamp_out    (tamp_out),
   .ts_valid    (ts_valid),
   .ts_value    (ts_value),
   .ts_chan     (ts_chan),
   .wake        (wake)
);

// File: tb/tamper_detect_bench.sv
module tamper_detect_bench;
   localparam int N  = 8;
   localparam int TW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          ctrl_we = 1'b0;
   logic [31:0]   ctrl_wdata = '0;
   logic [31:0]   ctrl_rdata;
   logic          slow_tick;
   logic          shield_ref = 1'b0;
   logic [N-1:0]  tamp_in;
   logic [N-1:0]  tamp_out;
   logic [TW-1:0] ts_count = '0;
   logic          flag_clr_we = 1'b0;
   logic [N-1:0]  flag_clr = '0;
   logic [N-1:0]  flags;
   logic          ts_valid;
   logic [TW-1:0] ts_value;
   logic [2:0]    ts_chan;
   logic          wake;

   logic [N-1:0] pin_drv = '0;
   logic [N-1:0] loop0 = '0, loop1 = '0, loop2 = '0;
   logic [N-1:0] out_q1, out_q2;
   logic [1:0]   tick_cnt;
   logic         ref_run = 1'b0;
   logic [2:0]   ref_cnt;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   tamper_detect u_tamper_detect (
      .clk (clk), .rst_n (rst_n), .enable (enable),
      .ctrl_we (ctrl_we), .ctrl_wdata (ctrl_wdata), .ctrl_rdata (ctrl_rdata),
      .slow_tick (slow_tick), .shield_ref (shield_ref),
      .tamp_in (tamp_in), .tamp_out (tamp_out), .ts_count (ts_count),
      .flag_clr_we (flag_clr_we), .flag_clr (flag_clr), .flags (flags),
      .ts_valid (ts_valid), .ts_value (ts_value), .ts_chan (ts_chan), .wake (wake)
   );

   always_ff @(posedge clk) begin
      out_q1   <= tamp_out;
      out_q2   <= out_q1;
      tick_cnt <= rst_n ? tick_cnt + 2'd1 : 2'd0;
      if (!ref_run) ref_cnt <= 3'd0;
      else if (ref_cnt == 3'd4) begin
         ref_cnt    <= 3'd0;
         shield_ref <= ~shield_ref;
      end else ref_cnt <= ref_cnt + 3'd1;
   end

   assign slow_tick = rst_n && (tick_cnt == 2'd0);
   assign tamp_in = (loop0 & tamp_out) | (loop1 & out_q1) | (loop2 & out_q2)
                  | (~(loop0 | loop1 | loop2) & pin_drv);

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input logic [31:0] w, input logic en_after);
      @(negedge clk);
      enable     = 1'b0;
      ctrl_we    = 1'b1;
      ctrl_wdata = w;
      @(negedge clk);
      ctrl_we = 1'b0;
      cyc(6);
      enable = en_after;
      cyc(2);
   endtask

   task automatic clear_flags(input logic [N-1:0] m);
      @(negedge clk);
      flag_clr_we = 1'b1;
      flag_clr    = m;
      @(negedge clk);
      flag_clr_we = 1'b0;
      flag_clr    = '0;
   endtask

   task automatic t_reset;
      check("R1 ctrl", ctrl_rdata, 0);
      check("R1 flags", flags, 0);
      check("R1 ts_valid", ts_valid, 0);
      check("R1 wake", wake, 0);
      check("R1 tamp_out", tamp_out, 0);
   endtask

   task automatic t_lock;
      cfg(32'h0000_0001, 1'b0);
      check("R2 write while disabled", ctrl_rdata, 32'h1);
      enable = 1'b1;
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      ctrl_we = 1'b0;
      cyc(1);
      check("R2 write while enabled ignored", ctrl_rdata, 32'h1);
      enable = 1'b0;
   endtask

   task automatic t_off;
      cfg(32'h00FF_0000, 1'b1);
      pin_drv = 8'hFF; cyc(8);
      pin_drv = 8'h00; cyc(8);
      check("R3 off channels set no flag", flags, 0);
   endtask

   task automatic t_wake;
      cfg(32'h0002_0004, 1'b1);          // ch1 wake, rising
      pin_drv[1] = 1'b1; cyc(6);
      check("R5 wake flag", flags, 8'h02);
      check("R5 wake output", wake, 1);
      check("R5 no timestamp", ts_valid, 0);
      clear_flags(8'h02);
      check("R8 clear", flags, 0);
      check("R5 wake drops", wake, 0);
      pin_drv[1] = 1'b0; cyc(6);
      check("R4 opposite edge ignored", flags, 0);
   endtask

   task automatic t_race;
      pin_drv[1] = 1'b1; cyc(6);
      check("R8 flag set again", flags, 8'h02);
      pin_drv[1] = 1'b0; cyc(6);
      pin_drv[1] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      flag_clr_we = 1'b1; flag_clr = 8'h02;
      @(negedge clk);
      flag_clr_we = 1'b0; flag_clr = '0;
      check("R8 event beats clear", flags, 8'h02);
      clear_flags(8'h02);
      pin_drv[1] = 1'b0;
      cyc(4);
   endtask

   task automatic t_capture;
      pin_drv[2] = 1'b1;
      cfg(32'h0008_00A0, 1'b1);          // ch2 capture falling, ch3 capture rising
      ts_count = 32'h1234;
      pin_drv[2] = 1'b0; cyc(6);
      check("R4 falling edge flag", flags, 8'h04);
      check("R6 ts_valid", ts_valid, 1);
      check("R6 ts_value", ts_value, 32'h1234);
      check("R6 ts_chan", ts_chan, 2);
      ts_count = 32'h5555;
      pin_drv[3] = 1'b1; cyc(6);
      check("R7 second flag", flags, 8'h0C);
      check("R7 value held", ts_value, 32'h1234);
      clear_flags(8'h08);
      check("R7 held after other clear", ts_valid, 1);
      clear_flags(8'h04);
      check("R7 released", ts_valid, 0);
      pin_drv[3] = 1'b0; cyc(6);
      ts_count = 32'h9999;
      pin_drv[3] = 1'b1; cyc(6);
      check("R7 new value", ts_value, 32'h9999);
      check("R7 new chan", ts_chan, 3);
      clear_flags(8'hFF);
      pin_drv = '0;
      cyc(4);
   endtask

   task automatic t_lowest;
      cfg(32'h0000_A000, 1'b1);          // ch6 and ch7 capture, falling... polarity 0
      pin_drv = 8'hC0; cyc(6);
      check("R4 rising ignored for falling pol", flags, 0);
      ts_count = 32'h0042;
      pin_drv = 8'h00; cyc(6);
      check("R6 both flags", flags, 8'hC0);
      check("R6 lowest channel recorded", ts_chan, 6);
      clear_flags(8'hFF);
   endtask

   task automatic t_debounce;
      cfg(32'h1030_0500, 1'b1);          // ch4,ch5 wake rising; ch4 debounced
      pin_drv[4] = 1'b1; cyc(6);
      pin_drv[4] = 1'b0; cyc(40);
      check("R9 short pulse filtered", flags, 0);
      pin_drv[4] = 1'b1; cyc(60);
      check("R9 long level detected", flags, 8'h10);
      pin_drv[5] = 1'b1; cyc(2);
      pin_drv[5] = 1'b0; cyc(6);
      check("R9 undebounced short pulse", flags[5], 1);
      clear_flags(8'hFF);
      pin_drv = '0;
      cyc(40);
      clear_flags(8'hFF);
   endtask

   task automatic t_shield;
      bit saw0 = 0, saw1 = 0;
      loop0 = 8'h40;
      cfg(32'h4040_3000, 1'b1);          // ch6 shield, edge and debounce bits set
      ref_run = 1'b1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (tamp_out[6]) saw1 = 1; else saw0 = 1;
      end
      check("R10 drives reference", {saw0, saw1}, 2'b11);
      check("R11 intact loop no flag", flags, 0);
      ref_run = 1'b0; cyc(10);
      loop0 = '0; loop1 = 8'h40; cyc(10);
      ref_run = 1'b1; cyc(60);
      check("R11 one cycle skew tolerated", flags, 0);
      ref_run = 1'b0; cyc(10);
      loop1 = '0; pin_drv = '0;
      ts_count = 32'h0077;
      ref_run = 1'b1; cyc(30);
      check("R10 broken loop flag", flags[6], 1);
      check("R10 ts_valid", ts_valid, 1);
      check("R10 ts_value", ts_value, 32'h0077);
      check("R10 ts_chan", ts_chan, 6);
      ref_run = 1'b0;
      enable = 1'b0;
      cyc(4);
      check("R10 drive off when disabled", tamp_out, 0);
      clear_flags(8'hFF);
   endtask

   task automatic t_disabled;
      cfg(32'h0001_0001, 1'b0);          // ch0 wake rising, left disabled
      pin_drv[0] = 1'b1; cyc(8);
      check("R12 no flag while disabled", flags, 0);
      enable = 1'b1; cyc(8);
      check("R12 no event on enable", flags, 0);
      pin_drv[0] = 1'b0;
      cyc(4);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_lock();
      t_off();
      t_wake();
      t_race();
      t_capture();
      t_lowest();
      t_debounce();
      t_shield();
      t_disabled();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule